// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive half of an I2C target peripheral. It samples the SCL and SDA lines with the system clock and finds start and stop conditions, keeping a bus-busy flag between them. The first frame after every start carries a 7-bit address and a direction bit. When the address equals the programmed own address and the direction is write, the block acknowledges and then takes in data bytes, acknowledging each one on its ninth clock.

On the CPU side the block offers a byte register, a receive-full flag, an interrupt flag gated by an enable, and a one-cycle read strobe. A single read strobe clears both flags together. If a byte is still unread when the ninth clock of a frame ends, the block holds SCL low until the CPU reads it. In this way a slow CPU pauses the bus master and no byte is lost.

Both lines are open-drain. The block never drives a line high: each output is an enable that pulls its line low.

Top module: `i2c_slave_rx`

## Requirements
- R1: While `enable` is 1, a start condition (SDA falling while SCL is high) sets `bus_busy` to 1.
- R2: A stop condition (SDA rising while SCL is high) clears `bus_busy` to 0 and ends any transfer.
- R3: The first frame after a start is sampled MSB first on SCL rising edges. Bits 7..1 are the address and bit 0 is read/write (0 = write). When bits 7..1 equal `own_addr` and bit 0 is 0, the block pulls SDA low for the whole ninth clock and raises `selected`.
- R4: On an address mismatch, or when bit 0 is 1, SDA stays released on the ninth clock. All later frames are ignored until the next start: no acknowledge, and neither `rx_full` nor `irq_flag` is set.
- R5: Once the block is selected, each data byte is sampled MSB first on SCL rising edges and acknowledged by SDA pulled low during its ninth clock.
- R6: `irq_flag` is set on the SCL falling edge that ends the eighth clock of every acknowledged frame, for the address frame and for data frames alike. `irq` is 1 exactly when `irq_flag` and `irq_en` are both 1.
- R7: At the end of a data byte, if `rx_full` is 0, the byte is loaded into `rx_data` and `rx_full` is set to 1.
- R8: At the SCL falling edge that ends a ninth clock, if `rx_full` is 1, `scl_oe` is asserted. It stays asserted, holding SCL low, for as long as `rx_full` remains 1.
- R9: A one-cycle `rd_strobe` clears `rx_full` and `irq_flag` and releases `scl_oe`, all on the next clock edge. `rx_data` keeps its value.
- R10: A repeated start (a start with no stop before it) restarts address matching, even after a mismatch.
- R11: While `enable` is 0, both output enables are released, `bus_busy` is 0, and no frame is acknowledged.
- R12: After reset, `scl_oe`, `sda_oe`, `rx_full`, `irq_flag`, `irq`, `bus_busy` and `selected` are all 0.
- R13: `scl_oe` and `sda_oe` are never both 1. A 1 on either one means that line is pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable |
| own_addr | input | 7 | Programmed own address |
| irq_en | input | 1 | Interrupt request enable |
| rd_strobe | input | 1 | One-cycle CPU read of the data byte |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| rx_data | output | 8 | Last received data byte |
| rx_full | output | 1 | Unread byte pending |
| irq_flag | output | 1 | Frame-acknowledged event flag |
| irq | output | 1 | Interrupt request to the CPU |
| bus_busy | output | 1 | Bus held between start and stop |
| selected | output | 1 | Addressed as write target in this transfer |

## Verification
The checker assumes the master changes SDA only while SCL is low, except to form start and stop conditions. It also assumes no stop can occur while the block holds SCL low, and that `rd_strobe` is a single-cycle pulse. The bench master holds SDA for several system clocks after each SCL falling edge and waits until SCL really reads high before it times a high phase. A stretch is therefore respected rather than overridden. The bench issues reads only as one-cycle pulses from the CPU-side process.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = 8;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_END,
        S_DATA,
        S_DATA_END,
        S_ACK,
        S_HOLD,
        S_SKIP
    } srx_state_e;

    // address frame: bits 7..1 address, bit 0 direction (0 = write)
    function automatic logic addr_hit(input logic [FRAME_W-1:0] frame,
                                      input logic [ADDR_W-1:0]  own);
        return (frame[FRAME_W-1:1] == own) && !frame[0];
    endfunction
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t q, d;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("i2c_srx_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        d       = q;
        d.chain = {q.chain[STAGES-2:0], line_i};
        d.prev  = q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{chain: '1, prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign level_o = q.chain[STAGES-1];
    assign rise_o  = q.chain[STAGES-1] & ~q.prev;
    assign fall_o  = ~q.chain[STAGES-1] & q.prev;
endmodule

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o,
    output logic busy_o
);
    logic busy_q, busy_d;

    assign start_o = enable & scl_lvl & sda_fall;
    assign stop_o  = enable & scl_lvl & sda_rise;

    always_comb begin
        busy_d = busy_q;
        if (!enable)      busy_d = 1'b0;
        else if (start_o) busy_d = 1'b1;
        else if (stop_o)  busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              irq_en,
    input  logic              rd_strobe,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [FRAME_W-1:0] rx_data,
    output logic              rx_full,
    output logic              irq_flag,
    output logic              irq,
    output logic              bus_busy,
    output logic              selected
);
    typedef struct packed {
        srx_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shift;
        logic [FRAME_W-1:0] data;
        logic               full;
        logic               flag;
        logic               sda_pull;
        logic               scl_pull;
        logic               sel;
    } rx_regs_t;

    rx_regs_t q, d;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    i2c_srx_cond u_cond (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .scl_lvl(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(start_det), .stop_o(stop_det), .busy_o(bus_busy)
    );

    always_comb begin
        d = q;
        // CPU read clears both flags; a set later in this cycle wins
        if (rd_strobe) begin
            d.full = 1'b0;
            d.flag = 1'b0;
        end

        if (!enable) begin
            d.st       = S_IDLE;
            d.sda_pull = 1'b0;
            d.scl_pull = 1'b0;
            d.sel      = 1'b0;
        end else if (start_det) begin
            d.st       = S_ADDR;
            d.cnt      = '0;
            d.sda_pull = 1'b0;
            d.scl_pull = 1'b0;
            d.sel      = 1'b0;
        end else if (stop_det) begin
            d.st       = S_IDLE;
            d.sda_pull = 1'b0;
            d.scl_pull = 1'b0;
            d.sel      = 1'b0;
        end else begin
            unique case (q.st)
                S_ADDR, S_DATA: begin
                    if (scl_rise) begin
                        d.shift = {q.shift[FRAME_W-2:0], sda_lvl};
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(FRAME_W - 1))
                            d.st = (q.st == S_ADDR) ? S_ADDR_END : S_DATA_END;
                    end
                end
                S_ADDR_END: begin
                    if (scl_fall) begin
                        if (addr_hit(q.shift, own_addr)) begin
                            d.st       = S_ACK;
                            d.sda_pull = 1'b1;
                            d.flag     = 1'b1;
                            d.sel      = 1'b1;
                        end else begin
                            d.st = S_SKIP;
                        end
                    end
                end
                S_DATA_END: begin
                    if (scl_fall) begin
                        d.st       = S_ACK;
                        d.sda_pull = 1'b1;
                        d.flag     = 1'b1;
                        if (!d.full) begin
                            d.data = q.shift;
                            d.full = 1'b1;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.sda_pull = 1'b0;
                        d.cnt      = '0;
                        if (d.full) begin
                            d.st       = S_HOLD;
                            d.scl_pull = 1'b1;
                        end else begin
                            d.st = S_DATA;
                        end
                    end
                end
                S_HOLD: begin
                    if (!d.full) begin
                        d.scl_pull = 1'b0;
                        d.st       = S_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign scl_oe   = q.scl_pull;
    assign sda_oe   = q.sda_pull;
    assign rx_data  = q.data;
    assign rx_full  = q.full;
    assign irq_flag = q.flag;
    assign irq      = q.flag & irq_en;
    assign selected = q.sel;
endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic rd_strobe,
    input logic start_det,
    input logic stop_det,
    input logic scl_fall,
    input logic scl_oe,
    input logic sda_oe,
    input logic rx_full,
    input logic irq_flag,
    input logic bus_busy
);
    // R1
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && enable) |=> bus_busy);

    // R2
    busy_off_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !bus_busy);

    // R6
    flag_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(scl_fall));

    // R3
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R8
    stretch_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> rx_full);

    // R9
    full_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_strobe));

    // R11
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_oe && !sda_oe && !bus_busy));

    // R13
    one_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_oe, sda_oe}));
endmodule

bind i2c_slave_rx i2c_srx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rd_strobe(rd_strobe),
    .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_full(rx_full),
    .irq_flag(irq_flag), .bus_busy(bus_busy)
);

// File: tb/i2c_slave_rx_test.sv
module i2c_slave_rx_test;
    localparam int HP = 20;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic irq_en = 1'b1;
    logic rd_strobe = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic auto_rd = 1'b0;
    logic done = 1'b0;
    logic scl_oe, sda_oe, rx_full, irq_flag, irq, bus_busy, selected;
    logic [7:0] rx_data;
    wire scl_line = m_scl & ~scl_oe;
    wire sda_line = m_sda & ~sda_oe;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    i2c_slave_rx uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(OWN),
        .irq_en(irq_en), .rd_strobe(rd_strobe), .scl_i(scl_line),
        .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_data(rx_data), .rx_full(rx_full), .irq_flag(irq_flag),
        .irq(irq), .bus_busy(bus_busy), .selected(selected)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic scl_down();
        m_scl = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; hp(); scl_up(); hp();
        m_sda = 1'b0; hp(); scl_down(); hp();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; hp(); scl_up(); hp();
        m_sda = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hp(); scl_up(); hp(); scl_down();
        end
        m_sda = 1'b1; hp(); scl_up();
        repeat (HP/2) @(negedge clk);
        ack = ~sda_line;
        repeat (HP/2) @(negedge clk);
        scl_down(); hp();
    endtask

    // driver side of the scoreboard
    task automatic push_byte(input logic [7:0] b, input string req);
        logic ack;
        exp_q.push_back(b);
        send_byte(b, ack);
        check(req, ack, 1'b1);
    endtask

    task automatic cpu_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // monitor side: read each pending byte and compare with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && rx_full) begin
                check("R6 flag with byte", irq_flag, 1'b1);
                check("R6 irq gating", irq, irq_en);
                if (exp_q.size() == 0) begin
                    check("R5 unexpected byte", rx_data, 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check("R5 R7 data byte", rx_data, e);
                end
                cpu_read();
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        // R12 reset state
        check("R12 reset outputs",
              {scl_oe, sda_oe, rx_full, irq_flag, irq, bus_busy, selected}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // matching write with manual read: stretch behaviour
        do_start();
        check("R1 busy after start", bus_busy, 1'b1);
        send_byte({OWN, 1'b0}, ack);
        check("R3 address ack", ack, 1'b1);
        check("R3 selected", selected, 1'b1);
        check("R6 address flag", irq_flag, 1'b1);
        check("R7 no full on address", rx_full, 1'b0);
        send_byte(8'hC3, ack);
        check("R5 data ack", ack, 1'b1);
        repeat (40) @(negedge clk);
        check("R8 scl held", scl_oe, 1'b1);
        check("R8 scl line low", scl_line, 1'b0);
        check("R13 sda released in stretch", sda_oe, 1'b0);
        check("R7 full set", rx_full, 1'b1);
        check("R7 data loaded", rx_data, 8'hC3);
        check("R6 irq", irq, 1'b1);
        cpu_read();
        check("R9 scl released", scl_oe, 1'b0);
        check("R9 full cleared", rx_full, 1'b0);
        check("R9 flag cleared", irq_flag, 1'b0);
        check("R9 data kept", rx_data, 8'hC3);

        // scoreboard stream, interrupt enabled
        auto_rd = 1'b1;
        push_byte(8'hA5, "R5 ack A5");
        push_byte(8'h00, "R5 ack 00");
        push_byte(8'hFF, "R5 ack FF");
        do_stop();
        check("R2 busy cleared", bus_busy, 1'b0);
        check("R2 deselected", selected, 1'b0);

        // interrupt masked, repeated start after mismatch
        irq_en = 1'b0;
        do_start();
        send_byte(8'h66, ack);
        check("R4 mismatch nack", ack, 1'b0);
        send_byte(8'h11, ack);
        check("R4 ignored data nack", ack, 1'b0);
        check("R4 ignored data no full", rx_full, 1'b0);
        do_start();
        check("R1 busy on repeated start", bus_busy, 1'b1);
        send_byte({OWN, 1'b0}, ack);
        check("R10 repeated start ack", ack, 1'b1);
        check("R6 masked irq", irq, 1'b0);
        push_byte(8'h3C, "R5 ack 3C");
        push_byte(8'h81, "R5 ack 81");
        do_stop();

        // read direction is refused
        irq_en = 1'b1;
        do_start();
        send_byte({OWN, 1'b1}, ack);
        check("R4 read nack", ack, 1'b0);
        send_byte(8'h42, ack);
        check("R4 read data nack", ack, 1'b0);
        check("R4 no flag", irq_flag, 1'b0);
        do_stop();

        // disabled block
        enable = 1'b0;
        repeat (4) @(negedge clk);
        do_start();
        check("R11 no busy", bus_busy, 1'b0);
        send_byte({OWN, 1'b0}, ack);
        check("R11 no ack", ack, 1'b0);
        check("R11 no flag", irq_flag, 1'b0);
        do_stop();
        enable = 1'b1;

        repeat (20) @(negedge clk);
        check("R5 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule